// File: doc/BRIEF.md
# Bytecode Instruction Sequencer with Branch Unit

This block drives instruction flow for a small register machine whose program is an array of 16-bit code words. It reads one word per instruction through a synchronous code-memory port and keeps the program counter. The counter always points past the current instruction before that instruction takes effect. Words that are not sequencing operations go to the external datapath on a one-cycle issue strobe. The datapath returns the flag-update class, the two operands that drive the condition flags, and an error indication.

The block holds a zero flag, a carry flag and a link register. It resolves absolute and relative branches on those flags, as well as calls and returns. A taken transfer whose destination lies outside the program length stops the machine with an error. The block also counts executed instructions against a fixed budget. The machine stops on a stop word, on an error, or when the budget is used up. Every halt condition is sticky until reset.

Top module: `word_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the PC, link register and both flags are zero and nothing is halted. The first code read is at address 0.
- R2: A word is requested with codeRdEn and arrives on codeData one cycle later. The PC advances by one for every word read. A word whose top nibble is neither 0xE nor 0xF is issued on opValid/opWord for exactly one cycle.
- R3: Flags are updated on an issued word according to flagKind. Value 1 (compare/subtract) sets Z = (opA == opB) and C = (opA >= opB). Value 2 (multiply) sets Z = (opA == 0 || opB == 0) and leaves C unchanged. Values 0 and 3 change nothing.
- R4: A branch word has top nibble 0xE. Bit 11 set means absolute: the target is the next code word. Bit 11 clear means relative: the target is the advanced PC plus the signed byte in bits 7:0. Bits 10:8 select the action: 0 always, 1 Z set, 2 Z clear, 3 C set, 4 C clear, 5 call, 6 return.
- R5: A conditional branch whose condition is false continues at the advanced PC. For the absolute form, that address is past the target word.
- R6: A call stores the advanced PC in the link register and then jumps. A return loads the PC from the link register.
- R7: A taken branch, call or return whose target is negative or at or above progLen halts with an error. A branch word with action 7 also halts with an error. In both cases the PC keeps its advanced value.
- R8: Fetching any word, including an absolute target word, from an address at or above progLen halts with an error. No read is issued.
- R9: A word with top nibble 0xF halts the machine without an error.
- R10: opErr asserted while opValid is high halts the machine with an error.
- R11: At most MAX_INSTR instructions execute. When another would start, the machine halts with budgetOut set and errorOut clear.
- R12: halted, errorOut and budgetOut stay set until reset. While halted, no code read is issued and the PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progLen | input | ADDR_W+1 | Program length in words |
| codeRdEn | output | 1 | Code read request |
| codeAddr | output | ADDR_W | Code read address |
| codeData | input | 16 | Code word, valid one cycle after the request |
| opValid | output | 1 | Datapath issue strobe |
| opWord | output | 16 | Issued instruction word |
| flagKind | input | 2 | Flag update class from the datapath |
| opA | input | OP_W | First flag operand |
| opB | input | OP_W | Second flag operand |
| opErr | input | 1 | Datapath error for the issued word |
| pcOut | output | ADDR_W+1 | Program counter |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| halted | output | 1 | Machine stopped |
| errorOut | output | 1 | Stopped by an error |
| budgetOut | output | 1 | Stopped by the instruction budget |

## Verification
The hardest case to reach from the ports is the budget limit. It needs a program that really runs for exactly MAX_INSTR instructions and one that would run forever. The bench instantiates the block with a small budget. It runs a straight-line program that ends on its last allowed instruction, then a one-word self loop that must end with budgetOut and the PC back on the loop word. Branch resolution is reached by placing a compare word first, so each flag combination is established through the datapath before the branch under test.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int WORD_W = 16;

  localparam logic [3:0] FAM_BRANCH = 4'hE;
  localparam logic [3:0] FAM_STOP   = 4'hF;

  localparam logic [2:0] BR_ALWAYS = 3'd0;
  localparam logic [2:0] BR_ZSET   = 3'd1;
  localparam logic [2:0] BR_ZCLR   = 3'd2;
  localparam logic [2:0] BR_CSET   = 3'd3;
  localparam logic [2:0] BR_CCLR   = 3'd4;
  localparam logic [2:0] BR_CALL   = 3'd5;
  localparam logic [2:0] BR_RET    = 3'd6;
  localparam logic [2:0] BR_BAD    = 3'd7;

  typedef enum logic [1:0] {
    FLG_NONE = 2'd0,
    FLG_CMP  = 2'd1,
    FLG_MUL  = 2'd2,
    FLG_RSV  = 2'd3
  } flag_kind_e;

  typedef enum logic [1:0] {
    TGT_REL  = 2'd0,
    TGT_ABS  = 2'd1,
    TGT_LINK = 2'd2
  } tgt_sel_e;

  typedef struct packed {
    logic     pcAdv;
    logic     pcJump;
    logic     lrSave;
    logic     flagUpd;
    logic     cntInc;
    logic     insLatch;
    tgt_sel_e tgtSel;
  } seq_strobe_t;
endpackage

// File: rtl/wseq_datapath.sv
module wseq_datapath
  import wseq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OP_W      = 16,
  parameter int MAX_INSTR = 65536
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         stb,
  input  logic                selLatched,
  input  logic [WORD_W-1:0]   codeData,
  input  logic [ADDR_W:0]     progLen,
  input  logic [1:0]          flagKind,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic [ADDR_W:0]     pc,
  output logic                zFlag,
  output logic                cFlag,
  output logic [WORD_W-1:0]   curWord,
  output logic                condMet,
  output logic                tgtBad,
  output logic                fetchBad,
  output logic                budgetDone
);
  localparam int TW = ((ADDR_W > WORD_W) ? ADDR_W : WORD_W) + 2;
  localparam int CW = $clog2(MAX_INSTR + 1);

  logic [ADDR_W:0]   lr;
  logic [WORD_W-1:0] insReg;
  logic [CW-1:0]     execCnt;
  logic [TW-1:0]     pcX, lrX, lenX, offX, absX, tgtFull;

  assign curWord  = selLatched ? insReg : codeData;
  assign pcX      = {{(TW-ADDR_W-1){1'b0}}, pc};
  assign lrX      = {{(TW-ADDR_W-1){1'b0}}, lr};
  assign lenX     = {{(TW-ADDR_W-1){1'b0}}, progLen};
  assign offX     = {{(TW-8){curWord[7]}}, curWord[7:0]};
  assign absX     = {{(TW-WORD_W){1'b0}}, codeData};

  always_comb begin
    case (stb.tgtSel)
      TGT_ABS:  tgtFull = absX;
      TGT_LINK: tgtFull = lrX;
      default:  tgtFull = pcX + offX;
    endcase
  end

  // top bit set means the sum went below zero
  assign tgtBad     = tgtFull[TW-1] || (tgtFull >= lenX);
  assign fetchBad   = (pc >= progLen);
  assign budgetDone = (execCnt == CW'(MAX_INSTR));

  always_comb begin
    case (curWord[10:8])
      BR_ALWAYS, BR_CALL, BR_RET: condMet = 1'b1;
      BR_ZSET: condMet = zFlag;
      BR_ZCLR: condMet = !zFlag;
      BR_CSET: condMet = cFlag;
      BR_CCLR: condMet = !cFlag;
      default: condMet = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      lr      <= '0;
      insReg  <= '0;
      execCnt <= '0;
      zFlag   <= 1'b0;
      cFlag   <= 1'b0;
    end else begin
      if (stb.pcJump)     pc <= tgtFull[ADDR_W:0];
      else if (stb.pcAdv) pc <= pc + 1'b1;
      if (stb.lrSave)   lr <= pc;
      if (stb.insLatch) insReg <= codeData;
      if (stb.cntInc)   execCnt <= execCnt + 1'b1;
      if (stb.flagUpd) begin
        case (flag_kind_e'(flagKind))
          FLG_CMP: begin
            zFlag <= (opA == opB);
            cFlag <= (opA >= opB);
          end
          FLG_MUL: zFlag <= (opA == '0) || (opB == '0);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wseq_control.sv
module wseq_control
  import wseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] curWord,
  input  logic              condMet,
  input  logic              tgtBad,
  input  logic              fetchBad,
  input  logic              budgetDone,
  input  logic              opErr,
  output seq_strobe_t       stb,
  output logic              selLatched,
  output logic              codeRdEn,
  output logic              opValid,
  output logic              halted,
  output logic              errorOut,
  output logic              budgetOut
);
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_TGT, ST_HALT} state_e;

  state_e state, stateNxt;
  logic   setErr, setBud, setStop;
  logic   isAbs;
  logic [2:0] brCond;

  assign isAbs      = curWord[11];
  assign brCond     = curWord[10:8];
  assign selLatched = (state == ST_TGT);

  always_comb begin
    stb      = '0;
    stb.tgtSel = TGT_REL;
    stateNxt = state;
    codeRdEn = 1'b0;
    opValid  = 1'b0;
    setErr   = 1'b0;
    setBud   = 1'b0;
    setStop  = 1'b0;
    case (state)
      ST_FETCH: begin
        if (fetchBad)        setErr = 1'b1;
        else if (budgetDone) setBud = 1'b1;
        else begin
          codeRdEn  = 1'b1;
          stb.pcAdv = 1'b1;
          stateNxt  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        stb.cntInc = 1'b1;
        stateNxt   = ST_FETCH;
        if (curWord[15:12] == FAM_STOP) begin
          setStop = 1'b1;
        end else if (curWord[15:12] == FAM_BRANCH) begin
          if (brCond == BR_BAD) begin
            setErr = 1'b1;
          end else if (brCond == BR_RET) begin
            stb.tgtSel = TGT_LINK;
            if (tgtBad) setErr = 1'b1;
            else        stb.pcJump = 1'b1;
          end else if (isAbs) begin
            if (fetchBad) setErr = 1'b1;
            else begin
              codeRdEn     = 1'b1;
              stb.pcAdv    = 1'b1;
              stb.insLatch = 1'b1;
              stateNxt     = ST_TGT;
            end
          end else if (condMet) begin
            if (tgtBad) setErr = 1'b1;
            else begin
              stb.pcJump = 1'b1;
              stb.lrSave = (brCond == BR_CALL);
            end
          end
        end else begin
          opValid = 1'b1;
          if (opErr) setErr = 1'b1;
          else       stb.flagUpd = 1'b1;
        end
      end
      ST_TGT: begin
        stb.tgtSel = TGT_ABS;
        stateNxt   = ST_FETCH;
        if (condMet) begin
          if (tgtBad) setErr = 1'b1;
          else begin
            stb.pcJump = 1'b1;
            stb.lrSave = (brCond == BR_CALL);
          end
        end
      end
      default: ;
    endcase
    if (setErr || setBud || setStop) stateNxt = ST_HALT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_FETCH;
      halted    <= 1'b0;
      errorOut  <= 1'b0;
      budgetOut <= 1'b0;
    end else begin
      state <= stateNxt;
      if (setErr || setBud || setStop) halted <= 1'b1;
      if (setErr) errorOut  <= 1'b1;
      if (setBud) budgetOut <= 1'b1;
    end
  end
endmodule

// File: rtl/word_sequencer.sv
module word_sequencer
  import wseq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OP_W      = 16,
  parameter int MAX_INSTR = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W:0]   progLen,
  output logic              codeRdEn,
  output logic [ADDR_W-1:0] codeAddr,
  input  logic [15:0]       codeData,
  output logic              opValid,
  output logic [15:0]       opWord,
  input  logic [1:0]        flagKind,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              opErr,
  output logic [ADDR_W:0]   pcOut,
  output logic              flagZ,
  output logic              flagC,
  output logic              halted,
  output logic              errorOut,
  output logic              budgetOut
);
  seq_strobe_t       stb;
  logic              selLatched, condMet, tgtBad, fetchBad, budgetDone;
  logic [WORD_W-1:0] curWord;

  wseq_datapath #(.ADDR_W(ADDR_W), .OP_W(OP_W), .MAX_INSTR(MAX_INSTR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selLatched(selLatched),
    .codeData(codeData), .progLen(progLen), .flagKind(flagKind),
    .opA(opA), .opB(opB), .pc(pcOut), .zFlag(flagZ), .cFlag(flagC),
    .curWord(curWord), .condMet(condMet), .tgtBad(tgtBad),
    .fetchBad(fetchBad), .budgetDone(budgetDone)
  );

  wseq_control u_ctl (
    .clk(clk), .rstN(rstN), .curWord(curWord), .condMet(condMet),
    .tgtBad(tgtBad), .fetchBad(fetchBad), .budgetDone(budgetDone),
    .opErr(opErr), .stb(stb), .selLatched(selLatched),
    .codeRdEn(codeRdEn), .opValid(opValid), .halted(halted),
    .errorOut(errorOut), .budgetOut(budgetOut)
  );

  assign codeAddr = pcOut[ADDR_W-1:0];
  assign opWord   = curWord;
endmodule

// File: rtl/word_sequencer_checker.sv
module word_sequencer_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W:0]   progLen,
  input logic              codeRdEn,
  input logic [ADDR_W-1:0] codeAddr,
  input logic              opValid,
  input logic [ADDR_W:0]   pcOut,
  input logic              halted,
  input logic              errorOut,
  input logic              budgetOut
);
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  a_r12_no_read_halted: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !codeRdEn);
  a_r12_pc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(pcOut));
  a_r8_read_in_range: assert property (@(posedge clk) disable iff (!rstN)
    codeRdEn |-> ({1'b0, codeAddr} < progLen));
  a_r7_error_halts: assert property (@(posedge clk) disable iff (!rstN)
    errorOut |-> halted);
  a_r11_budget_not_error: assert property (@(posedge clk) disable iff (!rstN)
    !(errorOut && budgetOut));
  a_r2_issue_single: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);
  a_r2_issue_no_read: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> !codeRdEn);
endmodule

bind word_sequencer word_sequencer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .progLen(progLen), .codeRdEn(codeRdEn),
  .codeAddr(codeAddr), .opValid(opValid), .pcOut(pcOut), .halted(halted),
  .errorOut(errorOut), .budgetOut(budgetOut)
);

// File: tb/word_sequencer_bench.sv
`timescale 1ns/1ps
module word_sequencer_bench;
  localparam int AW = 16;
  localparam int MAXI = 20;

  typedef struct packed {
    logic [15:0] cmpW;
    logic [15:0] brW;
    logic [15:0] extW;
    logic [16:0] expPc;
    logic        expErr;
  } vec_t;

  // compare word first sets flags, then branch at 1, word 2 is target/filler
  localparam vec_t VECS [14] = '{
    '{16'h1055, 16'hE004, 16'hF000, 17'd7,  1'b0},  // R4 always rel
    '{16'h1055, 16'hE103, 16'hF000, 17'd6,  1'b0},  // R4 Z set taken
    '{16'h1065, 16'hE103, 16'hF000, 17'd3,  1'b0},  // R5 Z set not taken
    '{16'h1065, 16'hE205, 16'hF000, 17'd8,  1'b0},  // R4 Z clear
    '{16'h1065, 16'hE302, 16'hF000, 17'd5,  1'b0},  // R4 C set
    '{16'h1045, 16'hE40A, 16'hF000, 17'd13, 1'b0},  // R4 C clear
    '{16'h1055, 16'hE40A, 16'hF000, 17'd3,  1'b0},  // R5 C clear not taken
    '{16'h1055, 16'hE0FD, 16'hF000, 17'd2,  1'b1},  // R7 negative
    '{16'h1055, 16'hE800, 16'h0014, 17'd21, 1'b0},  // R4 abs
    '{16'h1065, 16'hE900, 16'h0009, 17'd4,  1'b0},  // R5 abs not taken
    '{16'h1055, 16'hE800, 16'h0020, 17'd3,  1'b1},  // R7 abs at length
    '{16'h1065, 16'hEB00, 16'h001F, 17'd32, 1'b0},  // R7 last word ok
    '{16'h1055, 16'hE07F, 16'hF000, 17'd2,  1'b1},  // R7 rel beyond
    '{16'h1055, 16'hE700, 16'hF000, 17'd2,  1'b1}   // R7 illegal action
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [AW:0] progLen = 17'd32;
  logic        codeRdEn, opValid, opErr, flagZ, flagC, halted, errorOut, budgetOut;
  logic [AW-1:0] codeAddr;
  logic [15:0] codeData = 16'h0000;
  logic [15:0] opWord;
  logic [1:0]  flagKind;
  logic [15:0] opA, opB;
  logic [AW:0] pcOut;
  logic [15:0] mem [64];

  int checks = 0;
  int fails = 0;
  longint cycles = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    cycles <= cycles + 1;
    if (codeRdEn) codeData <= (codeAddr < 16'd64) ? mem[codeAddr[5:0]] : 16'hF000;
  end

  // datapath model: family 1 compare, 2 multiply, 3 faulting op
  always_comb begin
    flagKind = 2'd0;
    opErr = 1'b0;
    opA = {12'd0, opWord[7:4]};
    opB = {12'd0, opWord[3:0]};
    case (opWord[15:12])
      4'h1: flagKind = 2'd1;
      4'h2: flagKind = 2'd2;
      4'h3: opErr = 1'b1;
      default: ;
    endcase
  end

  word_sequencer #(.ADDR_W(AW), .OP_W(16), .MAX_INSTR(MAXI)) u_word_sequencer (
    .clk(clk), .rstN(rstN), .progLen(progLen), .codeRdEn(codeRdEn),
    .codeAddr(codeAddr), .codeData(codeData), .opValid(opValid),
    .opWord(opWord), .flagKind(flagKind), .opA(opA), .opB(opB),
    .opErr(opErr), .pcOut(pcOut), .flagZ(flagZ), .flagC(flagC),
    .halted(halted), .errorOut(errorOut), .budgetOut(budgetOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = 16'hF000;
  endtask

  task automatic runProg(input logic [AW:0] len);
    @(negedge clk);
    rstN = 1'b0;
    progLen = len;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check("R12 halted reached", halted, 1);
  endtask

  initial begin
    clearMem();
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 pc", pcOut, 0);
    check("R1 halted", halted, 0);
    check("R1 flags", {flagZ, flagC}, 0);
    rstN = 1'b1;
    #1;
    check("R1 first read", {codeRdEn, codeAddr}, {1'b1, 16'd0});

    // table of branch vectors
    for (int v = 0; v < 14; v++) begin
      clearMem();
      mem[0] = VECS[v].cmpW;
      mem[1] = VECS[v].brW;
      mem[2] = VECS[v].extW;
      runProg(17'd32);
      check($sformatf("R4/R5/R7 vec%0d pc", v), pcOut, VECS[v].expPc);
      check($sformatf("R7 vec%0d error", v), errorOut, VECS[v].expErr);
    end

    // R6 relative call and return
    clearMem();
    mem[0] = 16'hE503; mem[4] = 16'h1055; mem[5] = 16'hE600;
    runProg(17'd32);
    check("R6 rel call/return pc", pcOut, 2);
    check("R6 rel call no error", errorOut, 0);
    check("R3 compare equal flags", {flagZ, flagC}, 2'b11);

    // R6 absolute call, link past target word
    clearMem();
    mem[0] = 16'hED00; mem[1] = 16'd10; mem[10] = 16'hE600;
    runProg(17'd32);
    check("R6 abs call/return pc", pcOut, 3);

    // R3 multiply flags
    clearMem();
    mem[0] = 16'h1055; mem[1] = 16'h2030; mem[2] = 16'h2034;
    runProg(17'd32);
    check("R3 mul nonzero keeps C", {flagZ, flagC}, 2'b01);
    clearMem();
    mem[0] = 16'h1045; mem[1] = 16'h2030;
    runProg(17'd32);
    check("R3 mul zero sets Z", {flagZ, flagC}, 2'b10);

    // R10 datapath error
    clearMem();
    mem[0] = 16'h3000;
    runProg(17'd32);
    check("R10 error", errorOut, 1);
    check("R10 pc", pcOut, 1);

    // R8 fall off end
    clearMem();
    mem[0] = 16'h1055; mem[1] = 16'h1055;
    runProg(17'd2);
    check("R8 error", errorOut, 1);
    check("R8 pc", pcOut, 2);

    // R8 absolute branch as last word: target word lies beyond length
    clearMem();
    mem[0] = 16'hE800; mem[1] = 16'd0;
    runProg(17'd1);
    check("R8 ext fetch error", errorOut, 1);
    check("R8 ext fetch pc", pcOut, 1);

    // R11 exactly MAXI instructions end normally
    clearMem();
    for (int i = 0; i < MAXI - 1; i++) mem[i] = 16'h1055;
    runProg(17'd32);
    check("R9 stop no error", errorOut, 0);
    check("R11 exact budget not hit", budgetOut, 0);
    check("R9 stop pc", pcOut, MAXI);

    // R11 endless loop hits budget
    clearMem();
    mem[0] = 16'hE0FF;
    runProg(17'd32);
    check("R11 budget hit", budgetOut, 1);
    check("R11 budget not error", errorOut, 0);
    check("R11 pc on loop word", pcOut, 0);

    // R12 stays halted
    repeat (10) @(negedge clk);
    check("R12 sticky", {halted, budgetOut, codeRdEn}, 3'b110);
    check("R12 pc frozen", pcOut, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule